// File: doc/BRIEF.md
# Priority Interrupt Controller with Sequential and Nested Servicing

This block gathers interrupt requests from a fixed set of sources and offers them to a processor one at a time. The processor sees a request line and a vector that names the source. It answers with a one-cycle acknowledge when it accepts the request and with a one-cycle end-of-service pulse when the handler finishes. Source 0 has the highest priority and source N-1 the lowest. A pending bit is raised by a rising edge on a source line, so a source that stays high asks only once.

A mode input can be changed at any time and selects the servicing policy. In sequential mode nothing is offered while any service is active. Requests that arrive meanwhile stay pending and are offered in priority order once service ends. In nested mode a request of strictly higher priority than the innermost active service is offered at once and may preempt it. The in-service mask acts as a stack of interrupted levels. Each end-of-service retires the highest-priority active level, so the preempted level becomes the innermost service again.

Top module: `intc_nest_seq`

## Requirements
- R1: After reset `int_req` is low and no source is pending or in service.
- R2: A low-to-high transition on `irq_src[i]` makes source i pending from the next clock edge. A source held high raises no further request after its pending bit has been cleared.
- R3: While `int_req` is high, `int_vec` equals the lowest index among the pending sources, written as an unsigned binary number.
- R4: An `int_ack` sampled with `int_req` high clears the pending bit of the source on `int_vec` and marks that source in service. An `int_ack` sampled with `int_req` low has no effect.
- R5: With `nest_mode` low, `int_req` stays low while any source is in service.
- R6: An `int_eoi` pulse retires the in-service source with the lowest index. The other active levels and the pending bits are unchanged. `int_eoi` and `int_ack` in the same cycle perform both actions.
- R7: With `nest_mode` high, `int_req` is high whenever a pending source has a lower index than every in-service source.
- R8: With `nest_mode` high, a pending source whose index is equal to or higher than the lowest in-service index is not offered.
- R9: After the preempting service is retired, the preempted level is again the innermost service. Pending sources are judged against that level.
- R10: A change of `nest_mode` affects `int_req` in the same cycle, using the stored pending and in-service state.
- R11: A rising edge on a source in the same cycle as the acknowledge of that source leaves the source pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | N_SRC | Interrupt source lines, index 0 highest priority |
| nest_mode | input | 1 | 1 = nested preemption, 0 = sequential servicing |
| int_ack | input | 1 | Processor accepts the offered request |
| int_eoi | input | 1 | Processor finished the innermost handler |
| int_req | output | 1 | A request is offered |
| int_vec | output | $clog2(N_SRC) | Index of the offered source |

## Verification
Two pairs of events can fall in the same clock edge. An end-of-service can arrive together with an acknowledge, and a fresh source edge can arrive together with the acknowledge that clears the same source. The bench drives both pairs on purpose in nested mode: an end-of-service on the preempted level together with the acknowledge of a preempting request, and a re-raised source during its own acknowledge. It then judges the outcome through the later request and vector behaviour, which a behavioural reference model predicts. A long run of random source, acknowledge, end-of-service and mode activity then puts both pairs through many further states.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // Index of the lowest set bit (0 when the mask is empty).
  function automatic int first_set(input logic [31:0] m);
    int idx;
    logic found;
    idx = 0;
    found = 1'b0;
    for (int i = 0; i < 32; i++) begin
      if (m[i] && !found) begin
        idx = i;
        found = 1'b1;
      end
    end
    return idx;
  endfunction

  // One-hot mask of the lowest set bit (zero when the mask is empty).
  function automatic logic [31:0] first_mask(input logic [31:0] m);
    return m & (~m + 32'd1);
  endfunction
endpackage

// File: rtl/intc_edge_capture.sv
module intc_edge_capture #(
  parameter int N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src,
  input  logic             ack_fire,
  input  logic [N_SRC-1:0] ack_mask,
  output logic [N_SRC-1:0] pend,
  output logic [N_SRC-1:0] rise
);
  logic [N_SRC-1:0] src_q;
  logic [N_SRC-1:0] clr_mask;

  assign rise     = src & ~src_q;
  assign clr_mask = ack_fire ? ack_mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      pend  <= '0;
    end else begin
      src_q <= src;
      pend  <= (pend & ~clr_mask) | rise;
    end
  end

  // R2: an edge always leaves its source pending
  a_r2_rise_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((pend & $past(rise)) == $past(rise)));

  // R4: acknowledged source is cleared unless re-raised in that cycle (R11)
  a_r4_ack_clears_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !(|(ack_mask & rise))) |=> !(|(pend & $past(ack_mask))));
endmodule

// File: rtl/intc_service_stack.sv
module intc_service_stack #(
  parameter int N_SRC = 4,
  localparam int VEC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_fire,
  input  logic [N_SRC-1:0] ack_mask,
  input  logic             eoi,
  output logic             busy,
  output logic [VEC_W-1:0] top_idx
);
  import intc_pkg::*;

  logic [N_SRC-1:0] isr;
  logic [N_SRC-1:0] retire_mask;
  logic [N_SRC-1:0] set_mask;

  assign retire_mask = eoi ? N_SRC'(first_mask(32'(isr))) : '0;
  assign set_mask    = ack_fire ? ack_mask : '0;
  assign busy        = |isr;
  assign top_idx     = VEC_W'(first_set(32'(isr)));

  always_ff @(posedge clk) begin
    if (!rst_n) isr <= '0;
    else        isr <= (isr & ~retire_mask) | set_mask;
  end

  // R6: one end-of-service retires exactly one active level
  a_r6_eoi_retires_one: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack_fire && busy) |=> ($countones(isr) == $countones($past(isr)) - 1));

  // R9: levels below the retired one survive the end-of-service
  a_r9_outer_levels_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && busy) |=> ((isr & ($past(isr) & ~$past(retire_mask))) == ($past(isr) & ~$past(retire_mask))));

  // R4: an accepted request becomes an active level
  a_r4_ack_enters_service: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> (|(isr & $past(ack_mask))));
endmodule

// File: rtl/intc_select.sv
module intc_select #(
  parameter int N_SRC = 4,
  localparam int VEC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] pend,
  input  logic             busy,
  input  logic [VEC_W-1:0] top_idx,
  input  logic             nest_mode,
  input  logic             ack,
  output logic             req,
  output logic [VEC_W-1:0] vec,
  output logic             ack_fire,
  output logic [N_SRC-1:0] ack_mask
);
  import intc_pkg::*;

  logic any_pend;
  logic may_offer;

  assign any_pend  = |pend;
  assign vec       = VEC_W'(first_set(32'(pend)));
  assign may_offer = !busy || (nest_mode && (vec < top_idx));
  assign req       = any_pend && may_offer;
  assign ack_fire  = ack && req;
  assign ack_mask  = N_SRC'(1) << vec;

  // R5: sequential mode stays quiet during service
  a_r5_seq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!nest_mode && busy) |-> !req);

  // R8: nested offers only strictly higher priority than the innermost level
  a_r8_no_lower_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    (req && busy) |-> (vec < top_idx));

  // R3: the offered vector is a pending source
  a_r3_vec_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> pend[vec]);
endmodule

// File: rtl/intc_nest_seq.sv
module intc_nest_seq #(
  parameter int N_SRC = 4,
  localparam int VEC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_src,
  input  logic             nest_mode,
  input  logic             int_ack,
  input  logic             int_eoi,
  output logic             int_req,
  output logic [VEC_W-1:0] int_vec
);
  logic [N_SRC-1:0] pend;
  logic [N_SRC-1:0] rise;
  logic [N_SRC-1:0] ack_mask;
  logic             ack_fire;
  logic             busy;
  logic [VEC_W-1:0] top_idx;

  intc_edge_capture #(.N_SRC(N_SRC)) u_capture (
    .clk(clk), .rst_n(rst_n), .src(irq_src),
    .ack_fire(ack_fire), .ack_mask(ack_mask),
    .pend(pend), .rise(rise)
  );

  intc_service_stack #(.N_SRC(N_SRC)) u_stack (
    .clk(clk), .rst_n(rst_n), .ack_fire(ack_fire), .ack_mask(ack_mask),
    .eoi(int_eoi), .busy(busy), .top_idx(top_idx)
  );

  intc_select #(.N_SRC(N_SRC)) u_select (
    .clk(clk), .rst_n(rst_n), .pend(pend), .busy(busy), .top_idx(top_idx),
    .nest_mode(nest_mode), .ack(int_ack), .req(int_req), .vec(int_vec),
    .ack_fire(ack_fire), .ack_mask(ack_mask)
  );

  // R1: nothing offered in the first cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $rose(rst_n) |-> !int_req);
endmodule

// File: tb/test_intc_nest_seq.sv
`timescale 1ns/1ps
module test_intc_nest_seq;
  localparam int N = 4;
  localparam int CYC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_src = '0;
  logic nest_mode = 1'b0;
  logic int_ack = 1'b0;
  logic int_eoi = 1'b0;
  logic int_req;
  logic [1:0] int_vec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  bit [N-1:0] m_pend, m_isr, m_srcq;

  always #(CYC/2) clk = ~clk;

  intc_nest_seq #(.N_SRC(N)) i_intc_nest_seq (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .nest_mode(nest_mode),
    .int_ack(int_ack), .int_eoi(int_eoi), .int_req(int_req), .int_vec(int_vec)
  );

  function automatic int m_cand();
    for (int i = 0; i < N; i++) if (m_pend[i]) return i;
    return -1;
  endfunction

  function automatic int m_top();
    for (int i = 0; i < N; i++) if (m_isr[i]) return i;
    return N;
  endfunction

  function automatic bit m_req();
    int c;
    c = m_cand();
    if (c < 0) return 0;
    if (m_isr == 0) return 1;
    return nest_mode && (c < m_top());
  endfunction

  task automatic model_edge();
    bit fire;
    int av, top;
    fire = int_ack && m_req();
    av = m_cand();
    top = m_top();
    if (!rst_n) begin
      m_pend = '0; m_isr = '0; m_srcq = '0;
      return;
    end
    if (int_eoi && top < N) m_isr[top] = 1'b0;
    if (fire) begin
      m_isr[av] = 1'b1;
      m_pend[av] = 1'b0;
    end
    for (int i = 0; i < N; i++) if (irq_src[i] && !m_srcq[i]) m_pend[i] = 1'b1;
    m_srcq = irq_src;
  endtask

  task automatic compare(input string tag);
    bit er;
    er = m_req();
    checks++;
    if (int_req !== er) begin
      errors++;
      $display("FAIL %s int_req actual=%0b expected=%0b", tag, int_req, er);
    end else if (er) begin
      checks++;
      if (int_vec !== 2'(m_cand())) begin
        errors++;
        $display("FAIL %s int_vec actual=%0d expected=%0d", tag, int_vec, m_cand());
      end
    end
  endtask

  // apply inputs for one cycle, advance model, compare at the falling edge
  task automatic step(input logic [N-1:0] s, input bit mode, input bit ack,
                      input bit eoi, input string tag);
    irq_src = s; nest_mode = mode; int_ack = ack; int_eoi = eoi;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    int_ack = 1'b0; int_eoi = 1'b0;
    compare(tag);
  endtask

  task automatic expect_req(input bit r, input int v, input string tag);
    checks++;
    if (int_req !== r || (r && int_vec !== 2'(v))) begin
      errors++;
      $display("FAIL %s req/vec actual=%0b/%0d expected=%0b/%0d", tag, int_req, int_vec, r, v);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CYC * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) step('0, 0, 0, 0, "R1 in reset");
    rst_n = 1'b1;
    step('0, 0, 0, 0, "R1 after reset");
    expect_req(0, 0, "R1 idle");

    // sequential: two edges together, priority order
    step(4'b0110, 0, 0, 0, "R2 edges");
    expect_req(1, 1, "R3 lowest index first");
    step(4'b0110, 0, 1, 0, "R4 ack");
    expect_req(0, 0, "R5 sequential holds pending");
    step(4'b0110, 0, 1, 0, "R4 ack while idle ignored");
    step(4'b0110, 0, 0, 1, "R6 eoi");
    expect_req(1, 2, "R6 pending delivered after service");
    step(4'b0110, 0, 1, 0, "R4 ack second");
    step(4'b0110, 0, 0, 1, "R6 eoi second");
    expect_req(0, 0, "R2 held level no new request");

    // nested preemption and resume
    step(4'b0000, 1, 0, 0, "R7 lines low");
    step(4'b1000, 1, 0, 0, "R7 src3");
    step(4'b1000, 1, 1, 0, "R4 ack 3");
    step(4'b1010, 1, 0, 0, "R7 src1 arrives");
    expect_req(1, 1, "R7 preempt");
    step(4'b1010, 0, 0, 0, "R10 switch to sequential");
    expect_req(0, 0, "R10 sequential gate");
    step(4'b1010, 1, 0, 0, "R10 back to nested");
    expect_req(1, 1, "R10 nested again");
    step(4'b1010, 1, 1, 0, "R4 ack 1");
    step(4'b1110, 1, 0, 0, "R8 src2 lower than 1");
    expect_req(0, 0, "R8 no lower preempt");
    step(4'b1110, 1, 0, 1, "R9 retire 1");
    expect_req(1, 2, "R9 judged against level 3");
    step(4'b1110, 1, 1, 0, "R4 ack 2");
    step(4'b0110, 1, 0, 1, "R9 retire 2");
    step(4'b1110, 1, 0, 0, "R8 src3 equal level");
    expect_req(0, 0, "R8 equal not offered");

    // eoi together with ack: level 3 active, source 0 preempts
    step(4'b1111, 1, 0, 0, "R7 src0");
    expect_req(1, 0, "R7 src0 offered");
    step(4'b1111, 1, 1, 1, "R6 ack and eoi same cycle");
    expect_req(0, 0, "R6 level0 active, 3 pending blocked");
    step(4'b1111, 1, 0, 1, "R6 retire 0");
    expect_req(1, 3, "R6 pending 3 offered");

    // edge during own ack keeps pending
    step(4'b0000, 1, 0, 0, "R11 lines low");
    step(4'b0000, 1, 1, 0, "R11 ack 3");
    step(4'b0000, 1, 0, 1, "R11 retire 3");
    step(4'b0100, 1, 0, 0, "R11 src2 edge");
    step(4'b0000, 1, 0, 0, "R11 src2 low");
    step(4'b0100, 1, 1, 0, "R11 re-edge during ack");
    step(4'b0100, 1, 0, 1, "R11 retire 2");
    expect_req(1, 2, "R11 source 2 still pending");
    step(4'b0100, 1, 1, 0, "R11 ack again");
    step(4'b0100, 1, 0, 1, "R11 retire again");

    // random run against the model
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] s;
      s = N'($urandom);
      step(s, 1'($urandom % 2), ($urandom % 3) == 0, ($urandom % 4) == 0, "R3/R6/R7 random");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule